// File: doc/BRIEF.md
# System Control Register File

This block holds a processor's system-control and floating-point control registers behind a single-cycle register port. The port carries an index, write data, a write enable, a read enable and read data. Reads are combinational from the stored values, and writes land on the rising clock edge. The block does more than store words. Some registers clear the bits they do not implement. Others keep part of their old contents, or only let bits be set. Some indices are aliases that redirect to another register. A handful are read-only.

Certain writes also produce one-cycle pulses in the same cycle as the write. One pulse tells the translation caches to drop cached control state. The other tells the statistics logic to clear its counters. A synchronous active-high reset loads a defined state. Two registers are not cleared by reset: the identity word and the boot-time copy of the control word. The boot-time copy seeds the control word on each reset.

Top module: `sysctl_regfile`

## Requirements
- R1: Synchronous reset clears every register to zero except index 0 (identity) and index 2 (boot copy of the control word). Those two keep their values through reset and are written as plain 32-bit words.
- R2: After reset, the control word (index 1) equals the boot copy ANDed with 0x48002000, ORed with 0x00C50010. Bit 30, bit 27 (non-maskable-interrupt bit) and bit 13 come from the boot copy. Bits 23, 22, 18, 16 and 4 are forced to one.
- R3: After reset, the event mailbox (index 10) reads 1 and the translation-buffer type register (index 11) reads 1.
- R4: A write to the coprocessor access register (index 9) stores the write data ANDed with 0x80F00000.
- R5: A write to the FP exception control register (index 8) replaces only bits 30:29. All other bits keep their old value.
- R6: A write to the FP status/control register (index 5) replaces only the bits set in 0xFFF7009F. All other bits keep their old value.
- R7: Index 6 is the saturation alias of the FP status register: a write ORs data&0x08000000 into index 5, and a read returns index 5 with bit 27 cleared. Index 7 is the exception-flag alias: a write ORs data&0x0000009F into index 5, and a read returns index 5 with those bits cleared.
- R8: A write to index 4 ORs the data into the program status word (index 3). Its data may have only bit 27 set. A read of index 4 returns zero.
- R9: Indices 11 to 15 ignore writes. Index 11 always reads 1, and indices 12 to 15 read 0. Indices 21 to 31 read 0 and ignore writes.
- R10: A write to the control word stores the write data, but bit 27 keeps its old value. The write raises the invalidate pulse in the same cycle.
- R11: The invalidate pulse is also raised by a program-status write whose bits 4:0 (mode) differ from the stored mode, and by any write to indices 16 to 19. Other writes do not raise it.
- R12: A write of exactly 0x00000007 to index 20 raises the statistics-clear pulse in the same cycle. Any other value is stored without a pulse.
- R13: Read data is zero whenever read enable is low. Otherwise it shows the selected register in the same cycle, including the value written at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 5 | Register index |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write enable, acts at the clock edge |
| rd_en | input | 1 | Read enable |
| rd_data | output | 32 | Combinational read data |
| xlat_inval | output | 1 | One-cycle translation-state invalidate pulse |
| stats_clear | output | 1 | One-cycle statistics-clear pulse |

## Verification
On every cycle the assertions hold several invariants. Read data is zero while idle. The interrupt bit of the control word survives control-word writes. Pulses appear only for their causes and never during reset. The saturation alias only ever sets bits. The unimplemented bits of the access and exception registers stay clear, and the type register holds 1. Only the bench's scenarios can show the full merge arithmetic of each register, the alias read masks, the reset seeding from different boot words, and mode-change detection. They are checked against a behavioural model, in directed sequences and in a long random run.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int IDX_W  = 5;
    localparam int DW     = 32;
    localparam int SLOTS  = 1 << IDX_W;
    localparam int MODE_W = 5;

    typedef enum logic [IDX_W-1:0] {
        RID_MAINID    = 5'd0,
        RID_SCTL      = 5'd1,
        RID_SCTL_BOOT = 5'd2,
        RID_PSR       = 5'd3,
        RID_PSR_SAT   = 5'd4,
        RID_FPSC      = 5'd5,
        RID_FPSC_SAT  = 5'd6,
        RID_FPSC_EXC  = 5'd7,
        RID_FPEXC     = 5'd8,
        RID_CPAC      = 5'd9,
        RID_MBOX      = 5'd10,
        RID_TLBTYPE   = 5'd11,
        RID_FEAT0     = 5'd12,
        RID_FEAT1     = 5'd13,
        RID_CPUID     = 5'd14,
        RID_FPID      = 5'd15,
        RID_CTXID     = 5'd16,
        RID_REMAP_PRI = 5'd17,
        RID_REMAP_NRM = 5'd18,
        RID_DOMAIN    = 5'd19,
        RID_PERFCTL   = 5'd20
    } reg_id_e;

    // control word fields
    localparam logic [DW-1:0] SCTL_NMI_BIT   = 32'h0800_0000;
    localparam logic [DW-1:0] SCTL_BOOT_KEEP = 32'h4800_2000;
    localparam logic [DW-1:0] SCTL_FORCE_ONE = 32'h00C5_0010;
    // status and FP masks
    localparam logic [DW-1:0] PSR_SAT_MASK   = 32'h0800_0000;
    localparam logic [DW-1:0] FPSC_WR_MASK   = 32'hFFF7_009F;
    localparam logic [DW-1:0] FPSC_SAT_MASK  = 32'h0800_0000;
    localparam logic [DW-1:0] FPSC_EXC_MASK  = 32'h0000_009F;
    localparam logic [DW-1:0] FPEXC_WR_MASK  = 32'h6000_0000;
    localparam logic [DW-1:0] CPAC_WR_MASK   = 32'h80F0_0000;
    localparam logic [DW-1:0] PERF_STATS_CMD = 32'h0000_0007;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_FULL,
        WK_MERGE,
        WK_OR,
        WK_CLR
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e         kind;
        logic [IDX_W-1:0] tgt;
        logic [DW-1:0]    wmask;
        logic [DW-1:0]    rclr;
        logic             rzero;
        logic             inval;
    } reg_rule_t;

    function automatic reg_rule_t rule_of(logic [IDX_W-1:0] idx);
        reg_rule_t r;
        r.kind  = WK_NONE;
        r.tgt   = idx;
        r.wmask = '0;
        r.rclr  = '0;
        r.rzero = 1'b1;
        r.inval = 1'b0;
        case (idx)
            RID_MAINID, RID_SCTL_BOOT, RID_PSR, RID_MBOX, RID_PERFCTL: begin
                r.kind  = WK_FULL;
                r.rzero = 1'b0;
            end
            RID_CTXID, RID_REMAP_PRI, RID_REMAP_NRM, RID_DOMAIN: begin
                r.kind  = WK_FULL;
                r.rzero = 1'b0;
                r.inval = 1'b1;
            end
            RID_SCTL: begin
                r.kind  = WK_MERGE;
                r.wmask = ~SCTL_NMI_BIT;
                r.rzero = 1'b0;
                r.inval = 1'b1;
            end
            RID_PSR_SAT: begin
                r.kind  = WK_OR;
                r.tgt   = RID_PSR;
                r.wmask = PSR_SAT_MASK;
            end
            RID_FPSC: begin
                r.kind  = WK_MERGE;
                r.wmask = FPSC_WR_MASK;
                r.rzero = 1'b0;
            end
            RID_FPSC_SAT: begin
                r.kind  = WK_OR;
                r.tgt   = RID_FPSC;
                r.wmask = FPSC_SAT_MASK;
                r.rclr  = FPSC_SAT_MASK;
                r.rzero = 1'b0;
            end
            RID_FPSC_EXC: begin
                r.kind  = WK_OR;
                r.tgt   = RID_FPSC;
                r.wmask = FPSC_EXC_MASK;
                r.rclr  = FPSC_EXC_MASK;
                r.rzero = 1'b0;
            end
            RID_FPEXC: begin
                r.kind  = WK_MERGE;
                r.wmask = FPEXC_WR_MASK;
                r.rzero = 1'b0;
            end
            RID_CPAC: begin
                r.kind  = WK_CLR;
                r.wmask = CPAC_WR_MASK;
                r.rzero = 1'b0;
            end
            RID_TLBTYPE: begin
                r.rzero = 1'b0;
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic bit slot_stored(int s);
        case (s)
            int'(RID_MAINID), int'(RID_SCTL), int'(RID_SCTL_BOOT),
            int'(RID_PSR), int'(RID_FPSC), int'(RID_FPEXC), int'(RID_CPAC),
            int'(RID_MBOX), int'(RID_TLBTYPE), int'(RID_CTXID),
            int'(RID_REMAP_PRI), int'(RID_REMAP_NRM), int'(RID_DOMAIN),
            int'(RID_PERFCTL): return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit slot_survives(int s);
        return (s == int'(RID_MAINID)) || (s == int'(RID_SCTL_BOOT));
    endfunction

    function automatic logic [DW-1:0] slot_reset(int s, logic [DW-1:0] boot);
        case (s)
            int'(RID_SCTL):    return (boot & SCTL_BOOT_KEEP) | SCTL_FORCE_ONE;
            int'(RID_MBOX):    return 32'h0000_0001;
            int'(RID_TLBTYPE): return 32'h0000_0001;
            default:           return '0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [IDX_W-1:0] reg_idx,
    output reg_rule_t        rule
);

    always_comb begin
        rule = rule_of(reg_idx);
    end

endmodule

// File: rtl/sysctl_merge.sv
module sysctl_merge
    import sysctl_pkg::*;
(
    input  wr_kind_e      kind,
    input  logic [DW-1:0] wmask,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] new_val
);

    always_comb begin
        case (kind)
            WK_FULL:  new_val = wr_data;
            WK_MERGE: new_val = (wr_data & wmask) | (old_val & ~wmask);
            WK_OR:    new_val = old_val | (wr_data & wmask);
            WK_CLR:   new_val = wr_data & wmask;
            default:  new_val = old_val;
        endcase
    end

endmodule

// File: rtl/sysctl_sidefx.sv
module sysctl_sidefx
    import sysctl_pkg::*;
(
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              inval_hit,
    input  logic [MODE_W-1:0] cur_mode,
    output logic              xlat_inval,
    output logic              stats_clear
);

    logic live_wr;
    logic mode_move;

    assign live_wr   = wr_en && !rst;
    assign mode_move = (reg_idx == RID_PSR) && (wr_data[MODE_W-1:0] != cur_mode);

    always_comb begin
        xlat_inval  = live_wr && (inval_hit || mode_move);
        stats_clear = live_wr && (reg_idx == RID_PERFCTL) && (wr_data == PERF_STATS_CMD);
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [DW-1:0]    rd_data,
    output logic             xlat_inval,
    output logic             stats_clear
);

    reg_rule_t     rule;
    logic [DW-1:0] bank [SLOTS];
    logic [DW-1:0] old_val;
    logic [DW-1:0] new_val;
    logic          commit;

    sysctl_decode u_dec (
        .reg_idx (reg_idx),
        .rule    (rule)
    );

    assign old_val = bank[rule.tgt];
    assign commit  = wr_en && !rst && (rule.kind != WK_NONE);

    sysctl_merge u_mrg (
        .kind    (rule.kind),
        .wmask   (rule.wmask),
        .old_val (old_val),
        .wr_data (wr_data),
        .new_val (new_val)
    );

    sysctl_sidefx u_fx (
        .rst         (rst),
        .wr_en       (wr_en),
        .reg_idx     (reg_idx),
        .wr_data     (wr_data),
        .inval_hit   (rule.inval),
        .cur_mode    (bank[RID_PSR][MODE_W-1:0]),
        .xlat_inval  (xlat_inval),
        .stats_clear (stats_clear)
    );

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            if (!slot_stored(s)) begin : g_none
                assign bank[s] = '0;
            end else if (slot_survives(s)) begin : g_keep
                logic [DW-1:0] q;
                always_ff @(posedge clk) begin
                    if (commit && (rule.tgt == IDX_W'(s))) begin
                        q <= new_val;
                    end
                end
                assign bank[s] = q;
            end else begin : g_clr
                logic [DW-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= slot_reset(s, bank[RID_SCTL_BOOT]);
                    end else if (commit && (rule.tgt == IDX_W'(s))) begin
                        q <= new_val;
                    end
                end
                assign bank[s] = q;
            end
        end
    endgenerate

    assign rd_data = (rd_en && !rule.rzero) ? (old_val & ~rule.rclr) : '0;

endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk
    import sysctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] reg_idx,
    input logic [DW-1:0]    wr_data,
    input logic             wr_en,
    input logic             rd_en,
    input logic [DW-1:0]    rd_data,
    input logic             xlat_inval,
    input logic             stats_clear,
    input logic [DW-1:0]    sctl_q,
    input logic [DW-1:0]    fpsc_q,
    input logic [DW-1:0]    fpexc_q,
    input logic [DW-1:0]    cpac_q,
    input logic [DW-1:0]    tlbt_q
);

    // R13
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

    // R10
    nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == RID_SCTL) |=> (sctl_q[27] == $past(sctl_q[27])));

    // R10
    sctl_inval_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == RID_SCTL) |-> xlat_inval);

    // R12
    stats_cause_chk: assert property (@(posedge clk) disable iff (rst)
        stats_clear |-> (wr_en && reg_idx == RID_PERFCTL && wr_data == PERF_STATS_CMD));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> (!xlat_inval && !stats_clear));

    // R4
    cpac_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (cpac_q & ~CPAC_WR_MASK) == '0);

    // R5
    fpexc_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (fpexc_q & ~FPEXC_WR_MASK) == '0);

    // R9
    tlbt_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        tlbt_q == 32'h0000_0001);

    // R7
    sat_alias_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == RID_FPSC_SAT) |=> ((fpsc_q & $past(fpsc_q)) == $past(fpsc_q)));

    // R8
    psr_sat_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == RID_PSR_SAT) |-> ((wr_data & ~PSR_SAT_MASK) == '0));

endmodule

bind sysctl_regfile sysctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_idx     (reg_idx),
    .wr_data     (wr_data),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .xlat_inval  (xlat_inval),
    .stats_clear (stats_clear),
    .sctl_q      (bank[sysctl_pkg::RID_SCTL]),
    .fpsc_q      (bank[sysctl_pkg::RID_FPSC]),
    .fpexc_q     (bank[sysctl_pkg::RID_FPEXC]),
    .cpac_q      (bank[sysctl_pkg::RID_CPAC]),
    .tlbt_q      (bank[sysctl_pkg::RID_TLBTYPE])
);

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  idx = '0;
    logic [31:0] wd  = '0;
    logic        we  = 1'b0;
    logic        re  = 1'b0;
    logic [31:0] rd_data;
    logic        xlat_inval;
    logic        stats_clear;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m [32];

    always #4 clk = ~clk;

    sysctl_regfile uut (
        .clk         (clk),
        .rst         (rst),
        .reg_idx     (idx),
        .wr_data     (wd),
        .wr_en       (we),
        .rd_en       (re),
        .rd_data     (rd_data),
        .xlat_inval  (xlat_inval),
        .stats_clear (stats_clear)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s idx=%0d: actual %h expected %h", tag, what, idx, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read();
        if (!re) return 32'h0;
        case (idx) inside
            5'd4:           return 32'h0;
            5'd6:           return m[5] & ~32'h0800_0000;
            5'd7:           return m[5] & ~32'h0000_009F;
            [5'd12:5'd15]:  return 32'h0;
            [5'd21:5'd31]:  return 32'h0;
            default:        return m[idx];
        endcase
    endfunction

    function automatic logic exp_inval();
        if (!we) return 1'b0;
        if (idx inside {5'd1, 5'd16, 5'd17, 5'd18, 5'd19}) return 1'b1;
        return (idx == 5'd3) && (wd[4:0] != m[3][4:0]);
    endfunction

    function automatic logic exp_stats();
        return we && (idx == 5'd20) && (wd == 32'h7);
    endfunction

    task automatic model_write();
        case (idx)
            5'd0, 5'd2, 5'd3, 5'd10, 5'd16, 5'd17, 5'd18, 5'd19, 5'd20: m[idx] = wd;
            5'd1: m[1] = (wd & ~32'h0800_0000) | (m[1] & 32'h0800_0000);
            5'd4: m[3] = m[3] | (wd & 32'h0800_0000);
            5'd5: m[5] = (wd & 32'hFFF7_009F) | (m[5] & ~32'hFFF7_009F);
            5'd6: m[5] = m[5] | (wd & 32'h0800_0000);
            5'd7: m[5] = m[5] | (wd & 32'h0000_009F);
            5'd8: m[8] = (wd & 32'h6000_0000) | (m[8] & ~32'h6000_0000);
            5'd9: m[9] = wd & 32'h80F0_0000;
            default: ;
        endcase
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin
            if (i != 0 && i != 2) m[i] = 32'h0;
        end
        m[1]  = (m[2] & 32'h4800_2000) | 32'h00C5_0010;
        m[10] = 32'h1;
        m[11] = 32'h1;
    endtask

    task automatic step(string tag, int i, logic [31:0] d, bit w, bit r);
        @(negedge clk);
        idx = i[4:0];
        wd  = d;
        we  = w;
        re  = r;
        #1;
        check(tag, "rdata", rd_data, exp_read());
        check(tag, "inval", {31'h0, xlat_inval}, {31'h0, exp_inval()});
        check(tag, "stats", {31'h0, stats_clear}, {31'h0, exp_stats()});
        @(posedge clk);
        if (we && !rst) model_write();
    endtask

    task automatic do_reset(int n);
        @(negedge clk);
        rst = 1'b1;
        we  = 1'b0;
        re  = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_reset();
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m[i] = 32'h0;
        do_reset(3);
        // seed the two registers that survive reset
        step("R1", 0, 32'h4100_C0F1, 1, 0);
        step("R1", 2, 32'hFFFF_FFFF, 1, 0);
        step("R1", 10, 32'h0000_0055, 1, 0);
        step("R1", 16, 32'h0000_0012, 1, 0);
        step("R1", 8, 32'h6000_0000, 1, 0);
        do_reset(2);
        step("R1", 0, 0, 0, 1);
        step("R1", 2, 0, 0, 1);
        step("R1", 16, 0, 0, 1);
        step("R1", 8, 0, 0, 1);
        step("R2", 1, 0, 0, 1);
        step("R3", 10, 0, 0, 1);
        step("R3", 11, 0, 0, 1);
        // masked clear
        step("R4", 9, 32'hFFFF_FFFF, 1, 1);
        step("R4", 9, 0, 0, 1);
        // exception-control merge
        step("R5", 8, 32'hFFFF_FFFF, 1, 0);
        step("R5", 8, 0, 0, 1);
        step("R5", 8, 32'h2000_0000, 1, 0);
        step("R5", 8, 0, 0, 1);
        // status/control merge
        step("R6", 5, 32'hFFFF_FFFF, 1, 0);
        step("R6", 5, 0, 0, 1);
        step("R6", 5, 32'h0000_0000, 1, 0);
        step("R6", 5, 0, 0, 1);
        // aliases
        step("R7", 6, 32'hFFFF_FFFF, 1, 0);
        step("R7", 5, 0, 0, 1);
        step("R7", 6, 0, 0, 1);
        step("R7", 7, 32'h0000_01FF, 1, 0);
        step("R7", 5, 0, 0, 1);
        step("R7", 7, 0, 0, 1);
        step("R7", 6, 0, 0, 1);
        // saturation alias of status word
        step("R8", 3, 32'h0000_0013, 1, 0);
        step("R8", 4, 32'h0800_0000, 1, 0);
        step("R8", 3, 0, 0, 1);
        step("R8", 4, 0, 0, 1);
        // read-only and unimplemented
        step("R9", 11, 32'hFFFF_FFFF, 1, 1);
        step("R9", 11, 0, 0, 1);
        step("R9", 12, 32'hFFFF_FFFF, 1, 0);
        step("R9", 12, 0, 0, 1);
        step("R9", 14, 32'h0000_0003, 1, 0);
        step("R9", 14, 0, 0, 1);
        step("R9", 25, 32'hABCD_1234, 1, 0);
        step("R9", 25, 0, 0, 1);
        step("R9", 31, 32'h1111_1111, 1, 1);
        // control word keeps its interrupt bit
        step("R10", 1, 32'h0000_0000, 1, 0);
        step("R10", 1, 0, 0, 1);
        step("R10", 1, 32'hF7FF_FFFF, 1, 0);
        step("R10", 1, 0, 0, 1);
        // invalidate causes
        step("R11", 3, 32'h0800_0013, 1, 0);
        step("R11", 3, 32'h0800_001F, 1, 0);
        step("R11", 16, 32'h0000_0007, 1, 0);
        step("R11", 17, 32'h000A_8AA4, 1, 0);
        step("R11", 18, 32'h44E0_48E0, 1, 0);
        step("R11", 19, 32'h5555_5555, 1, 0);
        step("R11", 10, 32'h0000_0000, 1, 0);
        step("R11", 17, 0, 0, 1);
        // statistics clear
        step("R12", 20, 32'h0000_0007, 1, 0);
        step("R12", 20, 32'h0000_0006, 1, 0);
        step("R12", 20, 32'h0000_0107, 1, 0);
        step("R12", 20, 0, 0, 1);
        // idle read and same-cycle visibility
        step("R13", 1, 0, 0, 0);
        step("R13", 19, 32'h0BAD_F00D, 1, 1);
        step("R13", 19, 0, 0, 1);
        // reseed from a cleared boot copy
        step("R2", 2, 32'h0000_0000, 1, 0);
        do_reset(1);
        step("R2", 1, 0, 0, 1);
        step("R1", 0, 0, 0, 1);
        step("R3", 10, 0, 0, 1);
        // random traffic against the model
        for (int k = 0; k < 600; k++) begin
            int          ri;
            logic [31:0] rw;
            ri = int'($urandom_range(31, 0));
            rw = $urandom;
            if (ri == 4) rw = rw & 32'h0800_0000;
            if (ri == 20 && rw[0]) rw = 32'h7;
            step("R13", ri, rw, bit'($urandom_range(1, 0)), bit'($urandom_range(1, 0)));
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule